// File: doc/BRIEF.md
# Serial Flash Command State Tracker

This block sits behind the serial front end of a flash memory model. The front end hands it one whole opcode byte at a time, marked by a single-cycle strobe. The tracker holds the operating state that opcodes change on their own, without reference to the array: the write enable latch, the one-line versus four-line command mode, the power-down condition, the two-step software reset, and the one-shot volatile status write enable. It drives these as level flags to the rest of the model.

A combinational legality flag tells the front end whether the opcode on the bus may run in the present state. When an opcode that modifies memory or status is accepted, a one-cycle pulse carries its category to the array model. When the reset sequence completes, a one-cycle soft reset pulse is raised.

Top module: `flash_cmd_tracker`

## Requirements
- R1: After the asynchronous reset every flag output and both pulse outputs are 0. An opcode presented while `cmd_stb` is 0 changes nothing.
- R2: Opcode 0x06 sets `wr_latch` and opcode 0x04 clears it.
- R3: Opcode 0x38 sets `quad_mode` and opcode 0xFF clears it.
- R4: Opcode 0x99 is legal only while `rst_armed` is 1. When it is accepted, `soft_rst` is 1 for exactly the one cycle after the strobe. In that same cycle `wr_latch`, `vol_wen`, `quad_mode` and `rst_armed` read 0.
- R5: Opcode 0x66 sets `rst_armed`. Every other opcode received while the block is awake, whether legal or not, clears it. Opcode 0x99 without 0x66 directly before it produces no pulse.
- R6: Opcode 0xB9 sets `pwr_down`. While `pwr_down` is 1, only 0xAB is legal, and 0xAB clears `pwr_down`. Every other opcode leaves all state and both pulses unchanged.
- R7: The guarded opcodes are legal only while `wr_latch` is 1. These are the block erases (0x20, 0x52, 0xD8, 0x44), the chip erases (0x60, 0xC7), the programs (0x02, 0x32, 0x42) and the status writes (0x01, 0x31, 0x11). A status write is also legal while `vol_wen` is 1. An accepted guarded opcode clears `wr_latch` and, one cycle after its strobe, raises `wr_go` for one cycle with `wr_kind` set. The `wr_kind` codes are 1 block erase, 2 chip erase, 3 program, 4 non-volatile status, 5 volatile status, and 0 when there is no pulse. A refused guarded opcode produces no pulse.
- R8: Opcodes 0x60 and 0xC7 both report `wr_kind` 2.
- R9: Opcode 0x50 sets `vol_wen`. The next opcode of any kind clears it. A status write accepted while `vol_wen` is 1 reports `wr_kind` 5.
- R10: The legal opcodes that have no state effect are the reads, ID reads and parameter commands (0x05, 0x35, 0x15, 0x90, 0x92, 0x94, 0x9F, 0x5A, 0x4B, 0x03, 0x0B, 0xEB, 0xE7, 0x3B, 0xBB, 0x6B, 0x0D, 0xBD, 0xED, 0x77, 0x0C, 0x0E, 0xC0, 0x75, 0x7A, 0x48), plus 0xAB while awake. Every byte not named in R2 to R10 is illegal. Apart from the clearing in R5 and R9, such bytes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | One-cycle strobe marking a complete opcode |
| cmd_byte | input | 8 | Decoded opcode byte |
| cmd_legal | output | 1 | Opcode on `cmd_byte` is legal in the current state (combinational) |
| wr_latch | output | 1 | Write enable latch |
| quad_mode | output | 1 | Four-line command mode |
| pwr_down | output | 1 | Power-down state |
| rst_armed | output | 1 | Reset armed by the previous opcode |
| vol_wen | output | 1 | Next status write targets volatile bits |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| wr_go | output | 1 | One-cycle pulse for an accepted guarded opcode |
| wr_kind | output | 3 | Category of the accepted guarded opcode |

## Verification
The bench sweeps all 256 opcode values from six prepared states: idle, latch set, reset armed, powered down, volatile enable, and latch plus volatile enable. Each result is compared with an arithmetic model of the flags and pulses.

The sweep targets the specific ways this block can go wrong:
- A tracker that arms on 0x66 but fails to disarm on an intervening byte fires a reset on 0x66 xx 0x99.
- One that lets power-down leak would set the latch or the arm flag while asleep.
- One that keeps the volatile enable for more than one opcode reports a volatile status write after an unrelated command.
- One that decodes only one of the two chip erase bytes reports the wrong category for the other.

Directed sequences also check that both pulses fall after a single cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int OP_W   = 8;
  localparam int KIND_W = 3;

  typedef enum logic [3:0] {
    OC_UNKNOWN, OC_PLAIN, OC_RST_ARM, OC_RST_EXEC, OC_QUAD_ON, OC_QUAD_OFF,
    OC_WEL_SET, OC_WEL_CLR, OC_VOL_EN, OC_ERASE, OC_CHIP_ERASE, OC_PROGRAM,
    OC_STATUS_WR, OC_PD_ENTER, OC_PD_EXIT
  } op_class_e;

  typedef enum logic [KIND_W-1:0] {
    WK_NONE = 3'd0, WK_BLOCK = 3'd1, WK_CHIP = 3'd2, WK_PROG = 3'd3,
    WK_STAT_NV = 3'd4, WK_STAT_VOL = 3'd5
  } wr_kind_e;

  function automatic op_class_e classify(input logic [OP_W-1:0] op);
    op_class_e c;
    case (op)
      8'h66: c = OC_RST_ARM;
      8'h99: c = OC_RST_EXEC;
      8'h38: c = OC_QUAD_ON;
      8'hFF: c = OC_QUAD_OFF;
      8'h06: c = OC_WEL_SET;
      8'h04: c = OC_WEL_CLR;
      8'h50: c = OC_VOL_EN;
      8'h20, 8'h52, 8'hD8, 8'h44: c = OC_ERASE;
      8'h60, 8'hC7: c = OC_CHIP_ERASE;
      8'h02, 8'h32, 8'h42: c = OC_PROGRAM;
      8'h01, 8'h31, 8'h11: c = OC_STATUS_WR;
      8'hB9: c = OC_PD_ENTER;
      8'hAB: c = OC_PD_EXIT;
      8'h05, 8'h35, 8'h15, 8'h90, 8'h92, 8'h94, 8'h9F, 8'h5A, 8'h4B,
      8'h03, 8'h0B, 8'hEB, 8'hE7, 8'h3B, 8'hBB, 8'h6B, 8'h0D, 8'hBD,
      8'hED, 8'h77, 8'h0C, 8'h0E, 8'hC0, 8'h75, 8'h7A, 8'h48: c = OC_PLAIN;
      default: c = OC_UNKNOWN;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/flash_opc_decode.sv
module flash_opc_decode
  import flash_cmd_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            armed,
  input  logic            wel,
  input  logic            vwen,
  input  logic            pd,
  output op_class_e       cls,
  output logic            legal,
  output logic            guarded
);
  always_comb begin
    cls     = classify(op);
    guarded = (cls == OC_ERASE) || (cls == OC_CHIP_ERASE) ||
              (cls == OC_PROGRAM) || (cls == OC_STATUS_WR);
    if (pd) begin
      legal = (cls == OC_PD_EXIT);
    end else begin
      case (cls)
        OC_UNKNOWN:    legal = 1'b0;
        OC_RST_EXEC:   legal = armed;
        OC_ERASE,
        OC_CHIP_ERASE,
        OC_PROGRAM:    legal = wel;
        OC_STATUS_WR:  legal = wel | vwen;
        default:       legal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/flash_power_ctl.sv
module flash_power_ctl
  import flash_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stb,
  input  op_class_e cls,
  output logic      pd
);
  logic pd_n;

  always_comb begin
    pd_n = pd;
    if (stb) begin
      if (pd) pd_n = (cls != OC_PD_EXIT);
      else    pd_n = (cls == OC_PD_ENTER);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd <= 1'b0;
    else        pd <= pd_n;
  end

  // R6
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && stb && cls != OC_PD_EXIT) |=> pd);
endmodule

// File: rtl/flash_reset_seq.sv
module flash_reset_seq
  import flash_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      awake_stb,
  input  op_class_e cls,
  output logic      armed,
  output logic      fire,
  output logic      pulse
);
  logic armed_n;

  always_comb begin
    fire    = awake_stb && (cls == OC_RST_EXEC) && armed;
    armed_n = armed;
    if (awake_stb) armed_n = (cls == OC_RST_ARM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pulse <= 1'b0;
    end else begin
      armed <= armed_n;
      pulse <= fire;
    end
  end

  // R4
  rst_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R5
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_stb && cls != OC_RST_ARM) |=> !armed);
endmodule

// File: rtl/flash_mode_regs.sv
module flash_mode_regs
  import flash_cmd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    awake_stb,
  input  op_class_e               cls,
  input  logic                    accept_guard,
  input  logic                    soft_clr,
  output logic                    wel,
  output logic                    quad,
  output logic                    vwen,
  output logic                    go,
  output logic [KIND_W-1:0]       kind
);
  logic wel_n, quad_n, vwen_n, go_n;
  logic [KIND_W-1:0] kind_n;

  always_comb begin
    wel_n  = wel;
    quad_n = quad;
    vwen_n = vwen;
    go_n   = accept_guard;
    kind_n = WK_NONE;
    if (accept_guard) begin
      case (cls)
        OC_ERASE:      kind_n = WK_BLOCK;
        OC_CHIP_ERASE: kind_n = WK_CHIP;
        OC_PROGRAM:    kind_n = WK_PROG;
        default:       kind_n = vwen ? WK_STAT_VOL : WK_STAT_NV;
      endcase
    end
    if (soft_clr) begin
      wel_n  = 1'b0;
      quad_n = 1'b0;
      vwen_n = 1'b0;
    end else if (awake_stb) begin
      vwen_n = (cls == OC_VOL_EN);
      if (cls == OC_WEL_SET) wel_n = 1'b1;
      else if (cls == OC_WEL_CLR || accept_guard) wel_n = 1'b0;
      if (cls == OC_QUAD_ON) quad_n = 1'b1;
      else if (cls == OC_QUAD_OFF) quad_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      quad <= 1'b0;
      vwen <= 1'b0;
      go   <= 1'b0;
      kind <= WK_NONE;
    end else begin
      wel  <= wel_n;
      quad <= quad_n;
      vwen <= vwen_n;
      go   <= go_n;
      kind <= kind_n;
    end
  end

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_stb && cls == OC_WEL_SET) |=> wel);
  // R9
  vol_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vwen && awake_stb && cls != OC_VOL_EN) |=> !vwen);
endmodule

// File: rtl/flash_cmd_tracker.sv
module flash_cmd_tracker
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [OP_W-1:0]   cmd_byte,
  output logic              cmd_legal,
  output logic              wr_latch,
  output logic              quad_mode,
  output logic              pwr_down,
  output logic              rst_armed,
  output logic              vol_wen,
  output logic              soft_rst,
  output logic              wr_go,
  output logic [KIND_W-1:0] wr_kind
);
  op_class_e cls;
  logic      guarded, awake_stb, accept_guard, fire;

  flash_opc_decode u_dec (
    .op(cmd_byte), .armed(rst_armed), .wel(wr_latch), .vwen(vol_wen),
    .pd(pwr_down), .cls(cls), .legal(cmd_legal), .guarded(guarded)
  );

  always_comb begin
    awake_stb    = cmd_stb && !pwr_down;
    accept_guard = awake_stb && guarded && cmd_legal;
  end

  flash_power_ctl u_pwr (
    .clk(clk), .rst_n(rst_n), .stb(cmd_stb), .cls(cls), .pd(pwr_down)
  );

  flash_reset_seq u_rst (
    .clk(clk), .rst_n(rst_n), .awake_stb(awake_stb), .cls(cls),
    .armed(rst_armed), .fire(fire), .pulse(soft_rst)
  );

  flash_mode_regs u_mode (
    .clk(clk), .rst_n(rst_n), .awake_stb(awake_stb), .cls(cls),
    .accept_guard(accept_guard), .soft_clr(fire),
    .wel(wr_latch), .quad(quad_mode), .vwen(vol_wen),
    .go(wr_go), .kind(wr_kind)
  );

  // R4
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!wr_latch && !quad_mode && !vol_wen && !rst_armed));
  // R7
  go_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> (!wr_latch && wr_kind != WK_NONE));
endmodule

// File: tb/sim_flash_cmd_tracker.sv
`timescale 1ns/1ps
module sim_flash_cmd_tracker;
  logic clk = 1'b0;
  logic rst_n;
  logic cmd_stb;
  logic [7:0] cmd_byte;
  logic cmd_legal, wr_latch, quad_mode, pwr_down, rst_armed, vol_wen;
  logic soft_rst, wr_go;
  logic [2:0] wr_kind;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit m_wel, m_quad, m_pd, m_arm, m_vol, m_rst, m_go;
  logic [2:0] m_kind;

  always #10 clk = ~clk;

  flash_cmd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
    .cmd_legal(cmd_legal), .wr_latch(wr_latch), .quad_mode(quad_mode),
    .pwr_down(pwr_down), .rst_armed(rst_armed), .vol_wen(vol_wen),
    .soft_rst(soft_rst), .wr_go(wr_go), .wr_kind(wr_kind)
  );

  function automatic bit is_blk(input logic [7:0] o);
    return o == 8'h20 || o == 8'h52 || o == 8'hD8 || o == 8'h44;
  endfunction
  function automatic bit is_chip(input logic [7:0] o);
    return o == 8'h60 || o == 8'hC7;
  endfunction
  function automatic bit is_prog(input logic [7:0] o);
    return o == 8'h02 || o == 8'h32 || o == 8'h42;
  endfunction
  function automatic bit is_stat(input logic [7:0] o);
    return o == 8'h01 || o == 8'h31 || o == 8'h11;
  endfunction
  function automatic bit is_plain(input logic [7:0] o);
    logic [7:0] lst [27] = '{8'h05, 8'h35, 8'h15, 8'h90, 8'h92, 8'h94, 8'h9F,
      8'h5A, 8'h4B, 8'h03, 8'h0B, 8'hEB, 8'hE7, 8'h3B, 8'hBB, 8'h6B, 8'h0D,
      8'hBD, 8'hED, 8'h77, 8'h0C, 8'h0E, 8'hC0, 8'h75, 8'h7A, 8'h48, 8'hAB};
    foreach (lst[i]) if (lst[i] == o) return 1'b1;
    return 1'b0;
  endfunction
  function automatic bit is_known(input logic [7:0] o);
    return is_blk(o) || is_chip(o) || is_prog(o) || is_stat(o) || is_plain(o) ||
      o == 8'h66 || o == 8'h99 || o == 8'h38 || o == 8'hFF || o == 8'h06 ||
      o == 8'h04 || o == 8'h50 || o == 8'hB9;
  endfunction
  function automatic bit m_legal(input logic [7:0] o);
    if (m_pd) return o == 8'hAB;
    if (!is_known(o)) return 1'b0;
    if (o == 8'h99) return m_arm;
    if (is_blk(o) || is_chip(o) || is_prog(o)) return m_wel;
    if (is_stat(o)) return m_wel | m_vol;
    return 1'b1;
  endfunction
  function automatic string tag_of(input logic [7:0] o);
    if (m_pd) return "R6";
    if (o == 8'h06 || o == 8'h04) return "R2";
    if (o == 8'h38 || o == 8'hFF) return "R3";
    if (o == 8'h99) return "R4";
    if (o == 8'h66) return "R5";
    if (o == 8'hB9) return "R6";
    if (is_chip(o)) return "R8";
    if (o == 8'h50 || m_vol) return "R9";
    if (is_blk(o) || is_prog(o) || is_stat(o)) return "R7";
    return "R10";
  endfunction

  task automatic m_apply(input logic [7:0] o);
    bit leg = m_legal(o);
    m_rst = 0; m_go = 0; m_kind = 3'd0;
    if (m_pd) begin
      if (o == 8'hAB) m_pd = 0;
      return;
    end
    if (o == 8'h99 && m_arm) begin
      m_rst = 1; m_wel = 0; m_quad = 0; m_vol = 0; m_arm = 0;
      return;
    end
    if (leg && (is_blk(o) || is_chip(o) || is_prog(o) || is_stat(o))) begin
      m_go = 1;
      m_kind = is_blk(o) ? 3'd1 : is_chip(o) ? 3'd2 : is_prog(o) ? 3'd3 :
               m_vol ? 3'd5 : 3'd4;
      m_wel = 0;
    end
    if (o == 8'h06) m_wel = 1;
    if (o == 8'h04) m_wel = 0;
    if (o == 8'h38) m_quad = 1;
    if (o == 8'hFF) m_quad = 0;
    if (o == 8'hB9) m_pd = 1;
    m_arm = (o == 8'h66);
    m_vol = (o == 8'h50);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] dut_vec();
    return {wr_latch, quad_mode, pwr_down, rst_armed, vol_wen, soft_rst, wr_go, wr_kind};
  endfunction
  function automatic logic [9:0] mod_vec();
    return {m_wel, m_quad, m_pd, m_arm, m_vol, m_rst, m_go, m_kind};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_stb = 0; cmd_byte = 8'h00;
    m_wel = 0; m_quad = 0; m_pd = 0; m_arm = 0; m_vol = 0; m_rst = 0; m_go = 0; m_kind = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(input logic [7:0] o, input bit check);
    string t;
    @(negedge clk);
    cmd_stb = 1; cmd_byte = o;
    #1;
    t = tag_of(o);
    if (check) chk({t, " legal"}, 32'(cmd_legal), 32'(m_legal(o)));
    m_apply(o);
    @(negedge clk);
    cmd_stb = 0;
    if (check) chk({t, " state"}, 32'(dut_vec()), 32'(mod_vec()));
  endtask

  task automatic idle_check(input string t);
    @(negedge clk);
    chk(t, {30'd0, soft_rst, wr_go}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_stb = 0; cmd_byte = 8'h00;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 reset", 32'(dut_vec()), 32'd0);
    // R1 no strobe, no effect
    cmd_byte = 8'h06;
    @(negedge clk); @(negedge clk);
    chk("R1 nostb", 32'(dut_vec()), 32'd0);

    // R4 pulse one cycle, R5 interrupted arm
    send(8'h06, 1); send(8'h38, 1); send(8'h66, 1); send(8'h99, 1);
    idle_check("R4 pulse width");
    send(8'h66, 1); send(8'h00, 1); send(8'h99, 1);
    chk("R5 no pulse", 32'(soft_rst), 32'd0);
    // R8 both chip erase bytes
    send(8'h06, 1); send(8'h60, 1);
    chk("R8 kind 60", 32'(wr_kind), 32'd2);
    idle_check("R7 go width");
    send(8'h06, 1); send(8'hC7, 1);
    chk("R8 kind C7", 32'(wr_kind), 32'd2);
    // R9 volatile one-shot
    send(8'h50, 1); send(8'h01, 1);
    chk("R9 vol kind", 32'(wr_kind), 32'd5);
    send(8'h50, 1); send(8'h05, 1); send(8'h01, 1);
    chk("R9 expired", 32'(wr_go), 32'd0);
    // R6 asleep ignores latch set
    send(8'hB9, 1); send(8'h06, 1); send(8'h66, 1);
    chk("R6 asleep", {30'd0, wr_latch, rst_armed}, 32'd0);
    send(8'hAB, 1);
    chk("R6 wake", 32'(pwr_down), 32'd0);

    // sweep: every opcode from six prepared states
    for (int s = 0; s < 6; s++) begin
      for (int op = 0; op < 256; op++) begin
        do_reset();
        case (s)
          1: send(8'h06, 0);
          2: send(8'h66, 0);
          3: send(8'hB9, 0);
          4: send(8'h50, 0);
          5: begin send(8'h38, 0); send(8'h06, 0); send(8'h50, 0); end
          default: ;
        endcase
        send(8'(op), 1);
        send(8'h00, 1);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule